// File: doc/BRIEF.md
# Display Memory DMA Engine

The engine moves data into the three display memories once a command decoder has latched the transfer parameters and pulsed the start input. It runs in one of three modes. A host copy reads words from the system bus and writes them into video RAM, colour RAM or vertical-scroll RAM. While it runs, a bus request holds the host CPU off the bus. A fill writes one byte value, supplied by a later data-port write, over a run of video RAM. An internal copy moves bytes from one video RAM location to another.

Every cycle is taken as a free memory slot, so a running transfer performs exactly one step per clock. A step is one read, where the mode needs one, and one write. Reads are combinational: the requested word or byte must be on the read-data input in the same cycle. Throughout the transfer the engine shows its live length and source registers, so the command decoder can read them back afterwards.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset the engine is idle. busy_o, bus_req_o, host_rd_o, vram_rd_o and mem_we_o are low, and len_o reads zero.
- R2: With mode_i = 00 (host copy), every running cycle drives host_rd_o with host_addr_o equal to the source register. In the same cycle it writes the returned word, as a word write (mem_byte_o low), to mem_addr_o in the memory chosen by target_i: 00 video RAM, 01 colour RAM, 10 vertical-scroll RAM. bus_req_o is high on every running cycle of a host copy and on no other cycle.
- R3: The length is a count of words. Each step decrements it before the test for zero, so a programmed length of N gives N steps, and a length of 0 gives 65536 steps.
- R4: After each step the low 16 bits of the source address increment, modulo 2^16. The upper 7 bits of the 23-bit source never change during a transfer.
- R5: After each step the destination address advances by inc_i, modulo 2^16.
- R6: A host copy into colour RAM (64 entries) or vertical-scroll RAM (40 entries) ends after the step that writes entry index mem_addr_o>>1 at or above the last entry, 63 or 39, even when length remains.
- R7: With mode_i = 01 (fill), the engine is busy but writes nothing until data_wr_i is high. From the next cycle on, it writes data_i[15:8] as byte writes (mem_byte_o high) into video RAM. It never raises bus_req_o.
- R8: With mode_i = 10 (internal copy), every running cycle reads the byte at vram_rd_addr_o, equal to the low 16 source bits. In the same cycle it writes that byte into video RAM at the destination, as a byte write. bus_req_o stays low.
- R9: When a transfer ends, busy_o and bus_req_o drop on the following clock and len_o reads zero. src_o holds the address one past the last one read.
- R10: A start pulse while busy, or a start with mode_i = 11, is ignored and leaves the engine's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse from the command decoder |
| mode_i | input | 2 | 00 host copy, 01 fill, 10 internal copy |
| target_i | input | 2 | Host copy target: 00 video, 01 colour, 10 vertical-scroll RAM |
| len_i | input | 16 | Transfer length in words (0 = 65536) |
| src_i | input | 23 | Source: host word address, or video RAM byte address in the low 16 bits |
| dst_i | input | 16 | Destination address |
| inc_i | input | 8 | Destination auto-increment |
| data_wr_i | input | 1 | Data-port write strobe (starts a fill) |
| data_i | input | 16 | Data-port word; high byte is the fill value |
| host_rd_o | output | 1 | Host bus read request |
| host_addr_o | output | 23 | Host bus word address |
| host_data_i | input | 16 | Host bus read data, same cycle |
| bus_req_o | output | 1 | Holds the host CPU off the bus |
| vram_rd_o | output | 1 | Video RAM read strobe (internal copy) |
| vram_rd_addr_o | output | 16 | Video RAM read byte address |
| vram_rd_data_i | input | 8 | Video RAM read data, same cycle |
| mem_we_o | output | 1 | Display memory write strobe |
| mem_sel_o | output | 2 | Target memory of the write |
| mem_byte_o | output | 1 | 1 = byte write, 0 = word write |
| mem_addr_o | output | 16 | Write address |
| mem_wdata_o | output | 16 | Write data (byte writes use bits 7:0) |
| busy_o | output | 1 | Transfer in progress |
| len_o | output | 16 | Live length register |
| src_o | output | 23 | Live source register |

## Verification
The hardest state to reach is the 65536-step transfer that a zero length produces. It needs a run long enough for the low source bits to wrap all the way round, and it must be checked write by write without the design being consulted. The bench drives one such run from a source whose upper bits are nonzero, and tracks the expected source and destination arithmetically on every write. The early stop for colour and vertical-scroll RAM is reached by placing the destination a few entries below the last one with ample length left. The held fill is reached by idling several cycles between the start and the data-port write.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {MODE_HOST = 2'b00, MODE_FILL = 2'b01, MODE_COPY = 2'b10} mode_e;
  typedef enum logic [1:0] {TGT_VRAM = 2'b00, TGT_CRAM = 2'b01, TGT_VSRAM = 2'b10} tgt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} state_e;
endpackage

// File: rtl/vdma_len_ctr.sv
module vdma_len_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic         clear_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);

  // decrement-then-test: the step that leaves zero behind is the last one
  assign last_o = (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= load_val_i;
    else if (clear_i) cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o - ONE;
  end

  // R3
  zero_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !load_i && cnt_o == '0) |=> cnt_o == '1);
endmodule

// File: rtl/vdma_src_ctr.sv
module vdma_src_ctr #(
  parameter int W      = 23,
  parameter int WRAP_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] src_o
);
  localparam int HI_W = W - WRAP_W;

  logic [WRAP_W-1:0] lo_nxt;
  assign lo_nxt = src_o[WRAP_W-1:0] + WRAP_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     src_o <= '0;
    else if (load_i) src_o <= load_val_i;
    else if (step_i) src_o <= {src_o[W-1:WRAP_W], lo_nxt};
  end

  // R4
  src_hi_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> src_o[W-1:WRAP_W] == $past(src_o[W-1:WRAP_W]));

  if (HI_W < 1) begin : g_bad
    initial $display("vdma_src_ctr: W must exceed WRAP_W");
  end
endmodule

// File: rtl/vdma_dst_ctr.sv
module vdma_dst_ctr #(
  parameter int W     = 16,
  parameter int INC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             step_i,
  output logic [W-1:0]     dst_o
);
  logic [INC_W-1:0] inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o <= '0;
      inc_q <= '0;
    end else if (load_i) begin
      dst_o <= load_val_i;
      inc_q <= inc_i;
    end else if (step_i) begin
      dst_o <= dst_o + W'(inc_q);
    end
  end

  // R5
  dst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> dst_o == W'($past(dst_o) + W'($past(inc_q))));
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import vdma_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SRC_W       = 23,
  parameter int WRAP_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int INC_W       = 8,
  parameter int DATA_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int CRAM_DEPTH  = 64,
  parameter int VSRAM_DEPTH = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        target_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              host_rd_o,
  output logic [SRC_W-1:0]  host_addr_o,
  input  logic [DATA_W-1:0] host_data_i,
  output logic              bus_req_o,
  output logic              vram_rd_o,
  output logic [ADDR_W-1:0] vram_rd_addr_o,
  input  logic [BYTE_W-1:0] vram_rd_data_i,
  output logic              mem_we_o,
  output logic [1:0]        mem_sel_o,
  output logic              mem_byte_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [SRC_W-1:0]  src_o
);
  localparam int IDX_W = ADDR_W - 1;
  localparam logic [IDX_W-1:0] CRAM_LAST  = IDX_W'(CRAM_DEPTH - 1);
  localparam logic [IDX_W-1:0] VSRAM_LAST = IDX_W'(VSRAM_DEPTH - 1);

  state_e            state_q;
  mode_e             mode_q;
  tgt_e              tgt_q;
  logic [BYTE_W-1:0] fill_q;
  logic [ADDR_W-1:0] dst_q;
  logic              accept, run, len_last, small_full, done;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-BYTE_W-1:0] unused_data_lo;

  assign unused_data_lo = data_i[DATA_W-BYTE_W-1:0];
  assign accept = (state_q == ST_IDLE) && start_i && (mode_i != 2'b11);
  assign run    = (state_q == ST_RUN);
  assign idx    = dst_q[ADDR_W-1:1];

  // short memories end the transfer once their last entry is written
  assign small_full = (mode_q == MODE_HOST) &&
                      (((tgt_q == TGT_CRAM)  && (idx >= CRAM_LAST)) ||
                       ((tgt_q == TGT_VSRAM) && (idx >= VSRAM_LAST)));
  assign done = run && (len_last || small_full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_HOST;
      tgt_q   <= TGT_VRAM;
      fill_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          mode_q  <= mode_e'(mode_i);
          tgt_q   <= tgt_e'(target_i);
          state_q <= (mode_e'(mode_i) == MODE_FILL) ? ST_WAIT : ST_RUN;
        end
        ST_WAIT: if (data_wr_i) begin
          fill_q  <= data_i[DATA_W-1:DATA_W-BYTE_W];
          state_q <= ST_RUN;
        end
        ST_RUN: if (done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vdma_len_ctr #(.W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .load_i(accept), .load_val_i(len_i),
    .step_i(run), .clear_i(done),
    .cnt_o(len_o), .last_o(len_last)
  );

  vdma_src_ctr #(.W(SRC_W), .WRAP_W(WRAP_W)) u_src (
    .clk_i, .rst_ni,
    .load_i(accept), .load_val_i(src_i),
    .step_i(run), .src_o(src_o)
  );

  vdma_dst_ctr #(.W(ADDR_W), .INC_W(INC_W)) u_dst (
    .clk_i, .rst_ni,
    .load_i(accept), .load_val_i(dst_i), .inc_i(inc_i),
    .step_i(run), .dst_o(dst_q)
  );

  assign busy_o         = (state_q != ST_IDLE);
  assign bus_req_o      = busy_o && (mode_q == MODE_HOST);
  assign host_rd_o      = run && (mode_q == MODE_HOST);
  assign host_addr_o    = src_o;
  assign vram_rd_o      = run && (mode_q == MODE_COPY);
  assign vram_rd_addr_o = src_o[ADDR_W-1:0];
  assign mem_we_o       = run;
  assign mem_addr_o     = dst_q;
  assign mem_sel_o      = (mode_q == MODE_HOST) ? tgt_q : TGT_VRAM;
  assign mem_byte_o     = (mode_q != MODE_HOST);

  always_comb begin
    unique case (mode_q)
      MODE_FILL: mem_wdata_o = DATA_W'(fill_q);
      MODE_COPY: mem_wdata_o = DATA_W'(vram_rd_data_i);
      default:   mem_wdata_o = host_data_i;
    endcase
  end

  // R2
  byte_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_byte_o) |-> !bus_req_o);
  // R7
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (!mem_we_o && !bus_req_o));
  // R9
  end_len_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_o == '0 && !bus_req_o));
  // R6
  cram_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_byte_o && mem_sel_o == TGT_CRAM && mem_addr_o[ADDR_W-1:1] >= CRAM_LAST)
    |=> !busy_o);
  // R10
  start_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && mem_we_o) |=> (len_o == $past(len_o) - LEN_W'(1)) || !busy_o);
endmodule

// File: tb/sim_vram_dma_engine.sv
module sim_vram_dma_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start, data_wr;
  logic [1:0]  mode, target;
  logic [15:0] len, dst, data;
  logic [22:0] src;
  logic [7:0]  inc;
  logic        host_rd, bus_req, vram_rd, mem_we, mem_byte, busy;
  logic [22:0] host_addr, src_o;
  logic [15:0] host_data, vram_rd_addr, mem_addr, mem_wdata, len_o;
  logic [7:0]  vram_rd_data;
  logic [1:0]  mem_sel;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  function automatic logic [15:0] hmem(input logic [22:0] a);
    return a[15:0] ^ {1'b0, a[22:16], 8'h00};
  endfunction
  function automatic logic [7:0] vmem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h96;
  endfunction

  assign host_data    = hmem(host_addr);
  assign vram_rd_data = vmem(vram_rd_addr);

  vram_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .target_i(target),
    .len_i(len), .src_i(src), .dst_i(dst), .inc_i(inc), .data_wr_i(data_wr), .data_i(data),
    .host_rd_o(host_rd), .host_addr_o(host_addr), .host_data_i(host_data), .bus_req_o(bus_req),
    .vram_rd_o(vram_rd), .vram_rd_addr_o(vram_rd_addr), .vram_rd_data_i(vram_rd_data),
    .mem_we_o(mem_we), .mem_sel_o(mem_sel), .mem_byte_o(mem_byte), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .busy_o(busy), .len_o(len_o), .src_o(src_o)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // one transfer; expected stream derived from the requirements
  task automatic run_case(input string rq, input logic [1:0] m, input logic [1:0] t,
                          input logic [15:0] ln, input logic [22:0] s, input logic [15:0] d,
                          input logic [7:0] ic, input logic [15:0] fw, input int exp_n,
                          input bit restart);
    logic [22:0] es;
    logic [15:0] ed, ew;
    int n, cyc, bad;
    es = s; ed = d; n = 0; cyc = 0; bad = 0;
    @(negedge clk);
    mode = m; target = t; len = ln; src = s; dst = d; inc = ic; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(rq, "busy after start", busy, 1);
    if (m == 2'b01) begin
      for (int k = 0; k < 3; k++) begin
        if (mem_we || bus_req) bad++;
        @(negedge clk);
      end
      chk("R7", "no write before data port", bad, 0);
      data = fw; data_wr = 1'b1;
      @(negedge clk);
      data_wr = 1'b0;
    end
    while (busy && cyc < 70000) begin
      start = restart && (cyc == 1);
      if (start) begin mode = 2'b00; len = 16'd200; src = 23'h0; dst = 16'h0; end
      if (bus_req !== (m == 2'b00)) bad++;
      if (mem_we) begin
        if (m == 2'b00) ew = hmem(es);
        else if (m == 2'b01) ew = {8'h00, fw[15:8]};
        else ew = {8'h00, vmem(es[15:0])};
        if (mem_addr !== ed || mem_wdata !== ew || mem_byte !== (m != 2'b00) ||
            mem_sel !== ((m == 2'b00) ? t : 2'b00) ||
            (m == 2'b00 && (host_addr !== es || !host_rd)) ||
            (m == 2'b10 && (vram_rd_addr !== es[15:0] || !vram_rd))) begin
          if (bad == 0)
            $display("FAIL %s write %0d: addr %0h data %0h expected addr %0h data %0h",
                     rq, n, mem_addr, mem_wdata, ed, ew);
          bad++;
        end
        es = {es[22:16], es[15:0] + 16'd1};
        ed = ed + 16'(ic);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    checks++;
    if (bad != 0) fails++;
    chk(rq, "write count", n, exp_n);
    chk("R9", "busy low at end", busy, 0);
    chk("R9", "bus_req low at end", bus_req, 0);
    chk("R9", "len reads zero", len_o, 0);
    chk("R4", "final source", src_o, es);
  endtask

  initial begin
    #(4 * 195000);
    fails++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end

  initial begin
    start = 0; data_wr = 0; mode = 0; target = 0; len = 0; dst = 0; data = 0; src = 0; inc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "bus_req", bus_req, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "host_rd", host_rd, 0);
    chk("R1", "vram_rd", vram_rd, 0);
    chk("R1", "len", len_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 host copy to video RAM, length sweep
    for (int l = 1; l <= 8; l++)
      run_case("R2", 2'b00, 2'b00, 16'(l), 23'h05_0010 + 23'(l), 16'(l * 256), 8'd2, 16'h0, l, 0);
    // R4 R5 source low-bit wrap and destination wrap
    run_case("R4", 2'b00, 2'b00, 16'd5, 23'h03_FFFE, 16'hFFFC, 8'd2, 16'h0, 5, 0);
    run_case("R5", 2'b00, 2'b00, 16'd4, 23'h00_0100, 16'hFFF0, 8'd7, 16'h0, 4, 0);
    // R6 colour RAM: entries 60..63 then stop; short run ends on length
    run_case("R6", 2'b00, 2'b01, 16'd10, 23'h00_0200, 16'h0078, 8'd2, 16'h0, 4, 0);
    run_case("R6", 2'b00, 2'b01, 16'd3, 23'h00_0200, 16'h0000, 8'd2, 16'h0, 3, 0);
    // R6 vertical-scroll RAM: 40 entries from zero
    run_case("R6", 2'b00, 2'b10, 16'd100, 23'h10_0000, 16'h0000, 8'd2, 16'h0, 40, 0);
    // R7 fill sweep
    for (int l = 1; l <= 4; l++)
      run_case("R7", 2'b01, 2'b00, 16'(l), 23'h0, 16'h0010 + 16'(l), 8'(l % 2 + 1), 16'hA53C + 16'(l << 8), l, 0);
    // R8 internal copy across the source wrap with upper bits set
    run_case("R8", 2'b10, 2'b00, 16'd6, 23'h7F_FFFD, 16'h0200, 8'd1, 16'h0, 6, 0);
    run_case("R8", 2'b10, 2'b00, 16'd3, 23'h00_1234, 16'hFFFF, 8'd3, 16'h0, 3, 0);
    // R10 start while busy ignored
    run_case("R10", 2'b00, 2'b00, 16'd4, 23'h00_0040, 16'h0400, 8'd2, 16'h0, 4, 1);
    // R10 reserved mode ignored
    @(negedge clk);
    mode = 2'b11; len = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "reserved mode busy", busy, 0);
    chk("R10", "reserved mode len", len_o, 0);
    chk("R10", "reserved mode write", mem_we, 0);
    // R3 zero length means 65536 words
    run_case("R3", 2'b00, 2'b00, 16'd0, 23'h12_0000, 16'h0000, 8'd2, 16'h0, 65536, 0);

    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    end
    $finish;
  end
endmodule